// File: doc/BRIEF.md
# Packet Buffer Access Port

This block sits between a 16-bit host data port and an external packet buffer SRAM that is 32 bits wide. The host first loads a byte-address pointer, together with a transfer direction and an auto-advance mode. It then moves a packet through one data window, using byte or 16-bit accesses, at any alignment. The block turns those narrow, possibly unaligned accesses into full-doubleword SRAM reads and per-byte-lane SRAM writes.

Host writes are split into lane-masked entries and queued in a small write queue, which drains into memory one entry per cycle. In read direction the block fetches doublewords ahead of the host into a byte queue. Host reads are then served from that queue. A ready signal holds the host back whenever the queue it needs is short of room or short of data. Memory writes always take the SRAM port before prefetch reads, and prefetch does not start until every queued write has reached memory. A read that follows a write therefore sees the new data.

Top module: `pbuf_port`

## Requirements
- R1: While reset is held, the block shows its idle state: `ptr_cur` = 0, `wf_busy` = 0, `ram_rd_n` = 1 and `ram_we_n` = 4'b1111.
- R2: A cycle with `ptr_ld` high loads `ptr_addr` into the pointer, and latches the direction (`ptr_rd` = 1 selects read) and the auto-advance mode (`ptr_inc`). No data access is accepted in that cycle (`dat_ready` = 0), and the load discards all prefetched read bytes.
- R3: A byte write at byte address A changes only lane A[1:0] of doubleword A>>2. Lane k is bits 8k+7..8k and is enabled by `ram_we_n[k]` = 0. A word write puts `dat_wdata[7:0]` at A and `dat_wdata[15:8]` at A+1. When A[1:0] = 3, that word becomes two memory writes into two consecutive doublewords.
- R4: The SRAM read strobe and the write enables are never active in the same cycle. At most two write enables are low in any cycle. Memory writes take effect in the order the host issued them.
- R5: Memory reads always fetch a full doubleword. A byte read returns the byte at the pointer in `dat_rdata[7:0]`, with 0 in the upper byte. A word read returns {byte A+1, byte A} for all four alignments.
- R6: With auto-advance on, each accepted access advances the pointer by 1 (byte) or 2 (word), modulo 2^AW. With auto-advance off, the pointer stays the same: repeated reads return the same data, and repeated writes overwrite the same location.
- R7: A pointer load in read direction starts a prefetch from the new address, and reads are not ready until enough bytes have arrived. No prefetch read is issued while the write queue is not empty, so a read-back after writes returns the written data.
- R8: A host write stalls (`dat_ready` = 0) while the write queue has fewer free entries than the write needs. The write is accepted once room appears, and no data is lost.
- R9: `wf_busy` is high whenever the write queue holds an entry. It goes low only after the last queued memory write has been driven.
- R10: A data write in read direction, or a data read in write direction, is never accepted. It leaves the pointer, the write queue and memory unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr_ld | input | 1 | Load pointer and mode this cycle |
| ptr_addr | input | AW | Byte address to load |
| ptr_rd | input | 1 | Direction on load: 1 read, 0 write |
| ptr_inc | input | 1 | Auto-advance mode on load |
| ptr_cur | output | AW | Current pointer value |
| dat_rd | input | 1 | Host data read request |
| dat_wr | input | 1 | Host data write request |
| dat_word | input | 1 | Access size: 1 = 16-bit, 0 = 8-bit |
| dat_wdata | input | 16 | Host write data |
| dat_rdata | output | 16 | Host read data, valid when a read is accepted |
| dat_ready | output | 1 | Current request is accepted this cycle |
| wf_busy | output | 1 | Write queue not empty (read-only status) |
| ram_addr | output | AW-2 | SRAM doubleword address |
| ram_rd_n | output | 1 | SRAM read strobe, active low |
| ram_we_n | output | 4 | SRAM per-lane write enables, active low |
| ram_wdata | output | 32 | SRAM write data |
| ram_rdata | input | 32 | SRAM read data, one cycle after the strobe |

## Verification
A wrong queue pointer or level shows up at the ports within a few cycles. Read data arrives in the wrong byte order, a write lands in the wrong lane, or `dat_ready` stalls forever or accepts an access into a full queue. A stale prefetch after a pointer load or a non-advancing read appears as old bytes on the very next accepted read. A read issued ahead of queued writes returns pre-write data on read-back. Every alignment of the pointer is covered, including a word that straddles doublewords, a wrap at the top of the address space, and a run of straddling writes long enough to fill the write queue.

// File: rtl/pbuf_pkg.sv
package pbuf_pkg;

    typedef enum logic {
        DIR_WR = 1'b0,
        DIR_RD = 1'b1
    } dir_e;

    // Byte-lane mask of the first doubleword touched by a host write.
    function automatic logic [3:0] first_lanes(input logic [1:0] off, input logic word);
        return word ? (4'b0011 << off) : (4'b0001 << off);
    endfunction

    // Host write data placed on the memory lanes of the first doubleword.
    function automatic logic [31:0] first_data(input logic [1:0] off, input logic [15:0] wdata);
        return {16'h0000, wdata} << {off, 3'b000};
    endfunction

endpackage

// File: rtl/pbuf_wfifo.sv
module pbuf_wfifo #(
    parameter int DEPTH = 4,
    parameter int DW    = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push_a,
    input  logic [DW-1:0]                data_a,
    input  logic                         push_b,
    input  logic [DW-1:0]                data_b,
    input  logic                         pop,
    output logic [DW-1:0]                head,
    output logic [$clog2(DEPTH):0]       level
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = PW + 1;

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] lvl;
    } fs_t;

    fs_t           f_q, f_d;
    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wp_b;

    always_comb begin
        f_d  = f_q;
        wp_b = f_q.wp + PW'(1);
        if (pop)
            f_d.rp = f_q.rp + PW'(1);
        if (push_a)
            f_d.wp = push_b ? f_q.wp + PW'(2) : wp_b;
        f_d.lvl = f_q.lvl + CW'(push_a) + CW'(push_b) - CW'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            f_q <= '0;
        else
            f_q <= f_d;
    end

    always_ff @(posedge clk) begin
        if (push_a)
            mem[f_q.wp] <= data_a;
        if (push_b)
            mem[wp_b] <= data_b;
    end

    assign head  = mem[f_q.rp];
    assign level = f_q.lvl;

endmodule

// File: rtl/pbuf_rbytes.sv
module pbuf_rbytes #(
    parameter int DEPTH = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   flush,
    input  logic                   push,
    input  logic [31:0]            push_word,
    input  logic [1:0]             push_lane,
    input  logic [1:0]             pop_n,
    output logic [7:0]             head0,
    output logic [7:0]             head1,
    output logic [$clog2(DEPTH):0] level
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = PW + 1;

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] lvl;
    } rs_t;

    rs_t                 r_q, r_d;
    logic [7:0]          mem [DEPTH];
    logic [2:0]          pcnt;
    logic [PW-1:0]       rp_n1;
    logic [3:0][PW-1:0]  slot;
    logic [3:0][1:0]     lane;
    logic [3:0][7:0]     wbyte;
    logic [3:0]          wen;

    assign pcnt  = 3'd4 - {1'b0, push_lane};
    assign rp_n1 = r_q.rp + PW'(1);

    // Bytes from lane push_lane upward go into consecutive slots.
    for (genvar j = 0; j < 4; j++) begin : g_lane
        assign slot[j]  = r_q.wp + PW'(j);
        assign lane[j]  = push_lane + 2'(j);
        assign wbyte[j] = push_word[{lane[j], 3'b000} +: 8];
        assign wen[j]   = push && !flush && (3'(j) < pcnt);
    end

    always_comb begin
        r_d = r_q;
        if (flush) begin
            r_d.rp  = r_q.wp;
            r_d.lvl = '0;
        end else begin
            r_d.rp = r_q.rp + PW'(pop_n);
            if (push)
                r_d.wp = r_q.wp + PW'(pcnt);
            r_d.lvl = r_q.lvl + (push ? CW'(pcnt) : CW'(0)) - CW'(pop_n);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            r_q <= '0;
        else
            r_q <= r_d;
    end

    always_ff @(posedge clk) begin
        for (int j = 0; j < 4; j++) begin
            if (wen[j])
                mem[slot[j]] <= wbyte[j];
        end
    end

    assign head0 = mem[r_q.rp];
    assign head1 = mem[rp_n1];
    assign level = r_q.lvl;

endmodule

// File: rtl/pbuf_port.sv
module pbuf_port
    import pbuf_pkg::*;
#(
    parameter int AW       = 17,
    parameter int WF_DEPTH = 4,
    parameter int RB_DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ptr_ld,
    input  logic [AW-1:0] ptr_addr,
    input  logic          ptr_rd,
    input  logic          ptr_inc,
    output logic [AW-1:0] ptr_cur,
    input  logic          dat_rd,
    input  logic          dat_wr,
    input  logic          dat_word,
    input  logic [15:0]   dat_wdata,
    output logic [15:0]   dat_rdata,
    output logic          dat_ready,
    output logic          wf_busy,
    output logic [AW-3:0] ram_addr,
    output logic          ram_rd_n,
    output logic [3:0]    ram_we_n,
    output logic [31:0]   ram_wdata,
    input  logic [31:0]   ram_rdata
);
    localparam int DWA = AW - 2;
    localparam int EW  = DWA + 36;
    localparam int WCW = $clog2(WF_DEPTH) + 1;
    localparam int RCW = $clog2(RB_DEPTH) + 1;

    typedef struct packed {
        logic [AW-1:0] ptr;
        dir_e          dir;
        logic          inc;
        logic [AW-1:0] fetch;
        logic          pend;
        logic [1:0]    plane;
    } st_t;

    st_t            s_q, s_d;

    logic [WCW-1:0] wlvl, wneed, wfree;
    logic [RCW-1:0] rlvl, rneed;
    logic [EW-1:0]  whead, ent_a, ent_b;
    logic [7:0]     h0, h1;
    logic [1:0]     off, pop_n;
    logic [AW-1:0]  step;
    logic [DWA-1:0] dw_here, dw_next;
    logic           split, wr_ok, rd_ok, flush, issue, mw;

    always_comb begin
        off   = s_q.ptr[1:0];
        split = dat_word && (off == 2'd3);
        wneed = split ? WCW'(2) : WCW'(1);
        wfree = WCW'(WF_DEPTH) - wlvl;
        rneed = dat_word ? RCW'(2) : RCW'(1);
        step  = dat_word ? AW'(2) : AW'(1);

        wr_ok = dat_wr && !ptr_ld && (s_q.dir == DIR_WR) && (wfree >= wneed);
        rd_ok = dat_rd && !ptr_ld && (s_q.dir == DIR_RD) && (rlvl >= rneed);
        pop_n = rd_ok ? (dat_word ? 2'd2 : 2'd1) : 2'd0;

        // A pointer load, or a read that does not advance, drops the prefetch.
        flush = ptr_ld || (rd_ok && !s_q.inc);
        mw    = (wlvl != '0);
        issue = !mw && (s_q.dir == DIR_RD) && !s_q.pend && !flush
                && (rlvl <= RCW'(RB_DEPTH - 4));

        s_d      = s_q;
        s_d.pend = issue;
        if (issue) begin
            s_d.plane = s_q.fetch[1:0];
            s_d.fetch = {s_q.fetch[AW-1:2] + DWA'(1), 2'b00};
        end
        if ((wr_ok || rd_ok) && s_q.inc)
            s_d.ptr = s_q.ptr + step;
        if (rd_ok && !s_q.inc)
            s_d.fetch = s_q.ptr;
        if (ptr_ld) begin
            s_d.ptr   = ptr_addr;
            s_d.dir   = ptr_rd ? DIR_RD : DIR_WR;
            s_d.inc   = ptr_inc;
            s_d.fetch = ptr_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            s_q <= '0;
        else
            s_q <= s_d;
    end

    assign dw_here = s_q.ptr[AW-1:2];
    assign dw_next = dw_here + DWA'(1);
    assign ent_a   = {dw_here, first_lanes(off, dat_word), first_data(off, dat_wdata)};
    assign ent_b   = {dw_next, 4'b0001, 24'h000000, dat_wdata[15:8]};

    pbuf_wfifo #(
        .DEPTH (WF_DEPTH),
        .DW    (EW)
    ) u_wf (
        .clk    (clk),
        .rst_n  (rst_n),
        .push_a (wr_ok),
        .data_a (ent_a),
        .push_b (wr_ok && split),
        .data_b (ent_b),
        .pop    (mw),
        .head   (whead),
        .level  (wlvl)
    );

    pbuf_rbytes #(
        .DEPTH (RB_DEPTH)
    ) u_rb (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push      (s_q.pend),
        .push_word (ram_rdata),
        .push_lane (s_q.plane),
        .pop_n     (pop_n),
        .head0     (h0),
        .head1     (h1),
        .level     (rlvl)
    );

    assign ptr_cur   = s_q.ptr;
    assign dat_ready = wr_ok || rd_ok;
    assign dat_rdata = dat_word ? {h1, h0} : {8'h00, h0};
    assign wf_busy   = mw;
    assign ram_addr  = mw ? whead[EW-1 -: DWA] : s_q.fetch[AW-1:2];
    assign ram_we_n  = mw ? ~whead[35:32] : 4'b1111;
    assign ram_wdata = whead[31:0];
    assign ram_rd_n  = !issue;

endmodule

// File: rtl/pbuf_port_chk.sv
module pbuf_port_chk #(
    parameter int AW = 17
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ptr_ld,
    input logic          dat_rd,
    input logic          dat_wr,
    input logic          dat_ready,
    input logic [AW-1:0] ptr_cur,
    input logic          wf_busy,
    input logic          ram_rd_n,
    input logic [3:0]    ram_we_n
);
    AST_PORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ram_rd_n && (ram_we_n != 4'b1111)));                           // R4
    AST_LANES_MAX2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~ram_we_n) <= 2);                                      // R4
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_ld |-> !dat_ready);                                           // R2
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ptr_ld && !dat_ready) |=> $stable(ptr_cur));                    // R6
    AST_BUSY_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wf_busy) |-> $past(ram_we_n != 4'b1111));                  // R9
    AST_NO_PREFETCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_rd_n |-> !wf_busy);                                          // R7
    AST_READY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        dat_ready |-> (dat_rd || dat_wr));                                // R10
endmodule

bind pbuf_port pbuf_port_chk #(.AW(AW)) u_chk (.*);

// File: tb/pbuf_port_tb.sv
module pbuf_port_tb;
    localparam int AW = 10;
    localparam int NB = 1 << AW;
    localparam int ND = NB / 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ptr_ld = 0, ptr_rd = 0, ptr_inc = 0;
    logic [AW-1:0] ptr_addr = '0, ptr_cur;
    logic dat_rd = 0, dat_wr = 0, dat_word = 0, dat_ready, wf_busy;
    logic [15:0] dat_wdata = '0, dat_rdata;
    logic [AW-3:0] ram_addr;
    logic ram_rd_n;
    logic [3:0] ram_we_n;
    logic [31:0] ram_wdata, ram_rdata;

    int checks = 0, errors = 0, viol = 0;
    int bptr = 0;
    bit binc = 0;
    logic [7:0]  gold [NB];
    logic [31:0] sram [ND];
    logic [15:0] exp_q [$];
    string       tag_q [$];

    always #10 clk = ~clk;

    pbuf_port #(.AW(AW), .WF_DEPTH(4), .RB_DEPTH(8)) u_dut (.*);

    function automatic logic [7:0] seed(input int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    function automatic logic [31:0] dw_gold(input int i);
        return {gold[4*i+3], gold[4*i+2], gold[4*i+1], gold[4*i]};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            ram_rdata <= '0;
            for (int i = 0; i < ND; i++)
                sram[i] <= {seed(4*i+3), seed(4*i+2), seed(4*i+1), seed(4*i)};
        end else begin
            if (!ram_rd_n) ram_rdata <= sram[ram_addr];
            for (int j = 0; j < 4; j++)
                if (!ram_we_n[j]) sram[ram_addr][8*j +: 8] <= ram_wdata[8*j +: 8];
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Monitor: port-level exclusivity and scoreboard of read data.
    initial forever begin
        @(negedge clk);
        #5;
        if (rst_n && !ram_rd_n && ram_we_n != 4'b1111) viol++;
        if (rst_n && dat_rd && dat_ready) begin
            if (exp_q.size() == 0) chk(0, "R5", "unexpected read", 32'(dat_rdata), 0);
            else begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(dat_rdata == e, t, "read data", 32'(dat_rdata), 32'(e));
            end
        end
    end

    task automatic load(input int a, input bit rd, input bit inc);
        ptr_ld = 1; ptr_addr = AW'(a); ptr_rd = rd; ptr_inc = inc;
        @(negedge clk);
        ptr_ld = 0;
        bptr = a; binc = inc;
    endtask

    task automatic host_wr(input bit word, input logic [15:0] d, output int stalls);
        bit r;
        stalls = 0;
        dat_wr = 1; dat_word = word; dat_wdata = d;
        do begin
            #5; r = dat_ready;
            if (!r) stalls++;
            @(negedge clk);
        end while (!r);
        dat_wr = 0;
        gold[bptr] = d[7:0];
        if (word) gold[(bptr+1) & (NB-1)] = d[15:8];
        if (binc) bptr = (bptr + (word ? 2 : 1)) & (NB-1);
    endtask

    task automatic host_rd(input bit word, input string tag, output int stalls);
        bit r;
        stalls = 0;
        exp_q.push_back(word ? {gold[(bptr+1) & (NB-1)], gold[bptr]} : {8'h00, gold[bptr]});
        tag_q.push_back(tag);
        dat_rd = 1; dat_word = word;
        do begin
            #5; r = dat_ready;
            if (!r) stalls++;
            @(negedge clk);
        end while (!r);
        dat_rd = 0;
        if (binc) bptr = (bptr + (word ? 2 : 1)) & (NB-1);
    endtask

    task automatic try_none(input bit rd, output bit acc);
        acc = 0;
        dat_rd = rd; dat_wr = !rd; dat_word = 1; dat_wdata = 16'hDEAD;
        for (int k = 0; k < 6; k++) begin
            #5; if (dat_ready) acc = 1;
            @(negedge clk);
        end
        dat_rd = 0; dat_wr = 0;
    endtask

    task automatic drain();
        bit b;
        do begin
            #5; b = wf_busy;
            @(negedge clk);
        end while (b);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int st, tot;
        bit acc;
        logic [31:0] keep;
        for (int a = 0; a < NB; a++) gold[a] = seed(a);
        repeat (3) @(negedge clk);
        #5;
        chk(ptr_cur == '0, "R1", "pointer in reset", 32'(ptr_cur), 0);
        chk(!wf_busy, "R1", "busy in reset", 32'(wf_busy), 0);
        chk(ram_rd_n && ram_we_n == 4'hF, "R1", "strobes in reset", {ram_rd_n, ram_we_n}, 5'h1F);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R9 and R3: single byte, lane 0, observed on the enables
        load(12'h050, 0, 1);
        host_wr(0, 16'h0077, st);
        #5;
        chk(wf_busy, "R9", "busy after write", 32'(wf_busy), 1);
        chk(ram_we_n == 4'b1110, "R3", "lane-0 enables", 32'(ram_we_n), 32'hE);
        @(negedge clk); #5;
        chk(!wf_busy, "R9", "busy after drain", 32'(wf_busy), 0);
        chk(sram[8'h14] == dw_gold(8'h14), "R3", "byte lane 0", sram[8'h14], dw_gold(8'h14));
        @(negedge clk);

        // R3: byte at lane 1, word straddling, words at offsets 1 and 2
        load(12'h081, 0, 0);
        host_wr(0, 16'h00C3, st);
        load(12'h087, 0, 1);
        host_wr(1, 16'hBEEF, st);
        #5; chk(ptr_cur == 10'h089, "R6", "pointer after word", 32'(ptr_cur), 32'h89);
        @(negedge clk);
        load(12'h091, 0, 1);
        host_wr(1, 16'h1234, st);
        load(12'h09A, 0, 1);
        host_wr(1, 16'h5678, st);
        drain();
        chk(sram[8'h20] == dw_gold(8'h20), "R3", "byte lane 1", sram[8'h20], dw_gold(8'h20));
        chk(sram[8'h21] == dw_gold(8'h21), "R3", "straddle low", sram[8'h21], dw_gold(8'h21));
        chk(sram[8'h22] == dw_gold(8'h22), "R3", "straddle high", sram[8'h22], dw_gold(8'h22));
        chk(sram[8'h24] == dw_gold(8'h24), "R3", "word off 1", sram[8'h24], dw_gold(8'h24));
        chk(sram[8'h26] == dw_gold(8'h26), "R3", "word off 2", sram[8'h26], dw_gold(8'h26));

        // R6 and R4: no advance, same location overwritten in order
        load(12'h0A0, 0, 0);
        host_wr(0, 16'h0011, st);
        host_wr(0, 16'h0022, st);
        drain();
        chk(ptr_cur == 10'h0A0, "R6", "pointer held", 32'(ptr_cur), 32'hA0);
        chk(sram[8'h28] == dw_gold(8'h28), "R4", "write order", sram[8'h28], dw_gold(8'h28));

        // R5 and R7: reads at every alignment, mixed sizes
        for (int o = 0; o < 4; o++) begin
            load(12'h100 + o, 1, 1);
            host_rd(1, "R5", st);
            chk(st > 0, "R7", "read waits for prefetch", st, 1);
            host_rd(0, "R5", st);
            host_rd(1, "R5", st);
            host_rd(1, "R5", st);
            host_rd(0, "R5", st);
            host_rd(1, "R5", st);
        end
        load(12'h085, 1, 1);
        for (int k = 0; k < 5; k++) host_rd(1, "R5", st);

        // R7: read-back right after writes, without waiting
        load(12'h180, 0, 1);
        for (int k = 0; k < 4; k++) host_wr(1, 16'hA100 + 16'(k), st);
        load(12'h180, 1, 1);
        for (int k = 0; k < 4; k++) host_rd(1, "R7", st);

        // R6: reads without advance repeat the same word
        load(12'h200, 1, 0);
        for (int k = 0; k < 3; k++) host_rd(1, "R6", st);
        #5; chk(ptr_cur == 10'h200, "R6", "read pointer held", 32'(ptr_cur), 32'h200);
        @(negedge clk);

        // R6: wrap at the top of the address space
        load(NB - 1, 0, 1);
        host_wr(1, 16'h5AA5, st);
        drain();
        #5; chk(ptr_cur == 10'h001, "R6", "pointer wrap", 32'(ptr_cur), 1);
        chk(sram[ND-1] == dw_gold(ND-1), "R6", "wrap low byte", sram[ND-1], dw_gold(ND-1));
        chk(sram[0] == dw_gold(0), "R6", "wrap high byte", sram[0], dw_gold(0));
        @(negedge clk);

        // R8: straddling words fill the write queue
        load(12'h303, 0, 1);
        tot = 0;
        for (int k = 0; k < 12; k++) begin
            host_wr(1, 16'hC000 + 16'(k * 3), st);
            tot += st;
        end
        chk(tot > 0, "R8", "stall seen", tot, 1);
        load(12'h303, 1, 1);
        for (int k = 0; k < 12; k++) host_rd(1, "R8", st);

        // R10: wrong-direction accesses are ignored
        load(12'h010, 1, 1);
        keep = sram[4];
        try_none(0, acc);
        #5;
        chk(!acc, "R10", "write in read dir", acc, 0);
        chk(!wf_busy && sram[4] == keep, "R10", "memory untouched", sram[4], keep);
        chk(ptr_cur == 10'h010, "R10", "pointer untouched", 32'(ptr_cur), 32'h10);
        @(negedge clk);
        load(12'h010, 0, 1);
        try_none(1, acc);
        chk(!acc, "R10", "read in write dir", acc, 0);

        // R2: load wins over a simultaneous write
        drain();
        ptr_ld = 1; ptr_addr = 10'h060; ptr_rd = 0; ptr_inc = 1;
        dat_wr = 1; dat_word = 0; dat_wdata = 16'h00FF;
        #5; chk(!dat_ready, "R2", "access during load", 32'(dat_ready), 0);
        @(negedge clk);
        ptr_ld = 0; dat_wr = 0;
        #5;
        chk(ptr_cur == 10'h060, "R2", "loaded pointer", 32'(ptr_cur), 32'h60);
        chk(!wf_busy, "R2", "no write queued", 32'(wf_busy), 0);
        @(negedge clk);

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R5", "reads outstanding", exp_q.size(), 0);
        chk(viol == 0, "R4", "strobe overlap", viol, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule